// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a 7-bit-address I2C target. It runs on a fast system clock and watches oversampled copies of the SCL and SDA bus lines. It recognises START and STOP conditions and compares the address byte against a configured address. On a controller write it shifts in each data byte, acknowledges it and presents it for one cycle on a parallel output. On a controller read it returns one constant byte from an input port, and repeats that byte for as long as the controller acknowledges.

The block never drives a bus line high. It only asserts open-drain pull-down enables, and the board or bench forms the wired-AND bus. After each SCL falling edge seen outside the idle state, it can hold SCL low for a programmable number of system cycles. A separate switch makes it refuse (NACK) controller data bytes, while it still acknowledges the address byte of every matching transaction.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While `rst_n` is low and right after reset, `scl_oe`, `sda_oe` and `rx_valid` are 0.
- R2: An SDA fall while SCL is high (START) restarts address reception from any state, including the middle of a data byte (repeated START). The partial byte is discarded.
- R3: An SDA rise while SCL is high (STOP) releases SDA and returns to idle. In idle, bus clocking without a new START is ignored, even if it carries a matching address: no ACK and no `rx_valid`.
- R4: Address bits are sampled on SCL rising edges, MSB first. Bits 7..1 of the first byte after START are compared to `own_addr`, and bit 0 is the direction (1 = controller reads). On a mismatch the block does not acknowledge and ignores the bus until the next START.
- R5: On a match, `sda_oe` rises after the SCL falling edge that ends the 8th bit. It stays high through the 9th clock and is released after the falling edge that ends that clock.
- R6: In a controller write, each complete 8-bit data byte appears on `rx_data` with `rx_valid` high for exactly one cycle. The address byte never raises `rx_valid`.
- R7: With `ack_data_en` at 0, controller data bytes are NACKed (SDA left high in the 9th clock) but are still presented on `rx_data`. The address byte is still acknowledged.
- R8: In a controller read, `tx_byte` is sent MSB first, one bit per SCL low phase, each bit set after a falling edge. A 0 bit is driven through `sda_oe`.
- R9: After each sent byte, SDA is sampled on the 9th rising edge. Low (ACK) sends `tx_byte` again. High (NACK) returns to idle with SDA released.
- R10: When `hold_cycles` is N > 0, every SCL falling edge detected outside idle raises `scl_oe` for exactly N consecutive system cycles. When N = 0, `scl_oe` never rises.
- R11: SCL falling edges detected in idle, such as after an address mismatch, are never stretched.
- R12: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL bus level (unsynchronised) |
| sda_i | input | 1 | SDA bus level (unsynchronised) |
| own_addr | input | ADDR_W (7) | Configured target address |
| tx_byte | input | DATA_W (8) | Constant byte returned on reads |
| ack_data_en | input | 1 | 1 = acknowledge controller data bytes |
| hold_cycles | input | HOLD_W (8) | SCL stretch length in system cycles, 0 = off |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | DATA_W (8) | Last received controller data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The assertions assume a well-behaved controller. SDA changes only while SCL is low, except at START and STOP. Each SCL phase lasts several system cycles longer than the synchroniser delay. No START or STOP is attempted while the target pulls SDA low. The bench controller model meets these conditions: it changes SDA a full half period after lowering SCL, and it waits on the wired-AND SCL level before timing its high phase, so it respects every stretch. Repeated START is issued only inside a data byte, where the target is not driving SDA.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_ACK_HOLD,
      ST_WAIT_MACK,
      ST_RECV,
      ST_SEND
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_tgt_sync needs at least two stages");
      end
   endgenerate

   // lines idle high, so the chain resets high to avoid a false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], pin_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl_o  = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~prev;
   assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_tgt_hold.sv
module i2c_tgt_hold #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_fall,
   input  logic              active,
   input  logic [HOLD_W-1:0] hold_len,
   output logic              scl_oe
);
   logic [HOLD_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (scl_fall && active && hold_len != '0) begin
         cnt <= hold_len;
      end else if (cnt != '0) begin
         cnt <= cnt - HOLD_W'(1);
      end
   end

   assign scl_oe = (cnt != '0);

   // R10: a stretch only ever starts right after a detected fall outside idle
   a_r10_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(scl_fall && active));

   // R11: a fall seen while idle never starts a stretch
   a_r11_idle_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && !active && !scl_oe) |=> !scl_oe);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start,
   input  logic              stop,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              ack_data_en,
   output logic              sda_oe,
   output logic              active,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam int IDX_W = $clog2(DATA_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  tx_cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shifted;
   logic [IDX_W-1:0]  tx_idx;
   logic              dir_tx;
   logic              first_ack;
   logic              sda_drv;

   always_comb begin
      shifted = {shreg[DATA_W-2:0], sda_lvl};
      tx_idx  = IDX_W'(DATA_W - 1) - IDX_W'(tx_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         tx_cnt    <= '0;
         shreg     <= '0;
         dir_tx    <= 1'b0;
         first_ack <= 1'b0;
         sda_drv   <= 1'b0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (start || stop) begin
            // bus conditions win over any clock edge in the same cycle
            state   <= start ? ST_ADDR : ST_IDLE;
            bit_cnt <= '0;
            tx_cnt  <= '0;
            shreg   <= '0;
            sda_drv <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               ST_ADDR, ST_RECV: begin
                  if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                     bit_cnt <= '0;
                     shreg   <= '0;
                     if (state == ST_ADDR) begin
                        if (shifted[DATA_W-1 -: ADDR_W] != own_addr) begin
                           state <= ST_IDLE;
                        end else begin
                           dir_tx    <= shifted[0];
                           first_ack <= 1'b1;
                           state     <= ST_ACK;
                        end
                     end else begin
                        rx_data   <= shifted;
                        rx_valid  <= 1'b1;
                        first_ack <= 1'b0;
                        state     <= ST_ACK;
                     end
                  end else begin
                     shreg   <= shifted;
                     bit_cnt <= bit_cnt + CNT_W'(1);
                  end
               end
               ST_WAIT_MACK: state <= sda_lvl ? ST_IDLE : ST_ACK_HOLD;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               ST_ACK: begin
                  sda_drv <= first_ack | ack_data_en;
                  state   <= ST_ACK_HOLD;
               end
               ST_ACK_HOLD: begin
                  if (dir_tx) begin
                     sda_drv <= ~tx_byte[DATA_W-1];
                     tx_cnt  <= CNT_W'(1);
                     state   <= ST_SEND;
                  end else begin
                     sda_drv <= 1'b0;
                     state   <= ST_RECV;
                  end
               end
               ST_SEND: begin
                  if (tx_cnt == CNT_W'(DATA_W)) begin
                     sda_drv <= 1'b0;
                     tx_cnt  <= '0;
                     state   <= ST_WAIT_MACK;
                  end else begin
                     sda_drv <= ~tx_byte[tx_idx];
                     tx_cnt  <= tx_cnt + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = sda_drv;
   assign active = (state != ST_IDLE);

   // R2: a START always lands in address reception
   a_r2_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state == ST_ADDR));

   // R3: a STOP always idles with SDA released
   a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> (state == ST_IDLE && !sda_oe));

   // R6: the data strobe is a single-cycle pulse
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R12: SDA drive moves only while SCL is low
   a_r12_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drv != $past(sda_drv)) |-> !scl_lvl);
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              ack_data_en,
   input  logic [HOLD_W-1:0] hold_cycles,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam int N_LINES = 2;
   localparam int L_SCL   = 0;
   localparam int L_SDA   = 1;

   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_width
         $error("address plus direction bit must fill one data byte");
      end
      if (HOLD_W < 1) begin : g_bad_hold
         $error("hold counter needs at least one bit");
      end
   endgenerate

   logic [N_LINES-1:0] pins;
   logic [N_LINES-1:0] lvl;
   logic [N_LINES-1:0] rise;
   logic [N_LINES-1:0] fall;
   logic               start;
   logic               stop;
   logic               active;

   assign pins[L_SCL] = scl_i;
   assign pins[L_SDA] = sda_i;

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_sync
         i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
         );
      end
   endgenerate

   assign start = fall[L_SDA] & lvl[L_SCL];
   assign stop  = rise[L_SDA] & lvl[L_SCL];

   i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_lvl     (lvl[L_SCL]),
      .scl_rise    (rise[L_SCL]),
      .scl_fall    (fall[L_SCL]),
      .sda_lvl     (lvl[L_SDA]),
      .start       (start),
      .stop        (stop),
      .own_addr    (own_addr),
      .tx_byte     (tx_byte),
      .ack_data_en (ack_data_en),
      .sda_oe      (sda_oe),
      .active      (active),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid)
   );

   i2c_tgt_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_fall (fall[L_SCL]),
      .active   (active),
      .hold_len (hold_cycles),
      .scl_oe   (scl_oe)
   );
endmodule

// File: tb/sim_i2c_tgt_stretch.sv
module sim_i2c_tgt_stretch;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;
   localparam int WD_CYCLES  = 150000;
   localparam logic [6:0] OWN = 7'h3A;
   localparam int NV = 6;
   // [31:25] addr7 [24:17] data [16] ack_en [15:8] hold [2] addr ack [1] data ack [0] rx seen
   localparam logic [31:0] VEC [NV] = '{
      {7'h3A, 8'hA5, 1'b1, 8'd0,  5'd0, 3'b111},
      {7'h3A, 8'h00, 1'b1, 8'd5,  5'd0, 3'b111},
      {7'h3A, 8'hFF, 1'b0, 8'd0,  5'd0, 3'b101},
      {7'h3B, 8'h5A, 1'b1, 8'd3,  5'd0, 3'b000},
      {7'h1D, 8'h3C, 1'b1, 8'd0,  5'd0, 3'b000},
      {7'h3A, 8'h81, 1'b1, 8'd12, 5'd0, 3'b111}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_c = 1'b1;
   logic       sda_c = 1'b1;
   logic [7:0] tx_byte = 8'hC6;
   logic       ack_data_en = 1'b1;
   logic [7:0] hold_cycles = 8'd0;
   logic       scl_oe, sda_oe, rx_valid;
   logic [7:0] rx_data;
   logic       scl_bus, sda_bus;

   int checks = 0, fails = 0;
   int rx_cnt = 0, run = 0, last_run = 0, hold_events = 0, hold_total = 0;
   logic [7:0] rx_last = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_bus = scl_c & ~scl_oe;
   assign sda_bus = sda_c & ~sda_oe;

   i2c_tgt_stretch u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .own_addr(OWN), .tx_byte(tx_byte), .ack_data_en(ack_data_en),
      .hold_cycles(hold_cycles), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .rx_data(rx_data), .rx_valid(rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  = rx_cnt + 1;
         rx_last = rx_data;
      end
      if (scl_oe) begin
         run        = run + 1;
         hold_total = hold_total + 1;
      end else if (run != 0) begin
         last_run    = run;
         run         = 0;
         hold_events = hold_events + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_up();
      scl_c = 1'b1;
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sda_c = b;
      cyc(H);
      scl_up();
      cyc(H);
      scl_c = 1'b0;
      cyc(H);
   endtask

   task automatic read_bit(output logic b);
      sda_c = 1'b1;
      cyc(H);
      scl_up();
      cyc(H/2);
      b = sda_bus;
      cyc(H/2);
      scl_c = 1'b0;
      cyc(H);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack_n);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      read_bit(ack_n);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) read_bit(v[i]);
   endtask

   task automatic start_c();
      if (!scl_c) begin
         sda_c = 1'b1;
         cyc(H);
         scl_up();
         cyc(H);
      end
      sda_c = 1'b0;
      cyc(H);
      scl_c = 1'b0;
      cyc(H);
   endtask

   task automatic stop_c();
      sda_c = 1'b0;
      cyc(H);
      scl_up();
      cyc(H);
      sda_c = 1'b1;
      cyc(H);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      fails = fails + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
      summary();
      $finish;
   end

   initial begin
      logic an, dn, b;
      logic [7:0] v;
      int base_rx, base_ev, base_tot;

      // R1: reset state
      cyc(5);
      chk(scl_oe == 1'b0, "R1 scl_oe in reset", scl_oe, 0);
      chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
      chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
      rst_n = 1'b1;
      cyc(5);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 outputs after reset", {scl_oe, sda_oe}, 0);

      // table of write transactions (R4 R5 R6 R7 R10 R11)
      for (int k = 0; k < NV; k++) begin
         logic [31:0] e;
         e = VEC[k];
         ack_data_en = e[16];
         hold_cycles = e[15:8];
         base_rx  = rx_cnt;
         base_tot = hold_total;
         start_c();
         send_byte({e[31:25], 1'b0}, an);
         chk(an == ~e[2], "R4 address ack", an, ~e[2]);
         chk(sda_oe == 1'b0, "R5 ack released after 9th clock", sda_oe, 0);
         base_ev = hold_events;
         send_byte(e[24:17], dn);
         chk(dn == ~e[1], "R7 data ack", dn, ~e[1]);
         stop_c();
         cyc(4);
         chk(rx_cnt - base_rx == int'(e[0]), "R6 strobe count", rx_cnt - base_rx, e[0]);
         if (e[0]) chk(rx_last == e[24:17], "R6 received byte", rx_last, e[24:17]);
         if (e[15:8] == 8'd0)
            chk(hold_total == base_tot, "R10 no stretch when zero", hold_total - base_tot, 0);
         else if (e[2])
            chk(last_run == int'(e[15:8]), "R10 stretch length", last_run, e[15:8]);
         else
            chk(hold_events == base_ev, "R11 no stretch after mismatch", hold_events - base_ev, 0);
      end

      // R8 R9: controller read with stretching
      ack_data_en = 1'b1;
      hold_cycles = 8'd4;
      start_c();
      send_byte({OWN, 1'b1}, an);
      chk(an == 1'b0, "R8 read address ack", an, 0);
      recv_byte(v);
      chk(v == tx_byte, "R8 first sent byte", v, tx_byte);
      chk(last_run == 4, "R10 stretch during read", last_run, 4);
      send_bit(1'b0);
      recv_byte(v);
      chk(v == tx_byte, "R9 byte repeated after ACK", v, tx_byte);
      send_bit(1'b1);
      base_ev = hold_events;
      read_bit(b);
      chk(b == 1'b1, "R9 released after NACK", b, 1);
      read_bit(b);
      chk(b == 1'b1 && sda_oe == 1'b0, "R9 idle after NACK", b, 1);
      chk(hold_events == base_ev, "R11 no stretch when idle", hold_events - base_ev, 0);
      stop_c();

      // R2: repeated START inside a data byte
      hold_cycles = 8'd0;
      base_rx = rx_cnt;
      start_c();
      send_byte({OWN, 1'b0}, an);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      start_c();
      send_byte({OWN, 1'b0}, an);
      chk(an == 1'b0, "R2 address ack after repeated START", an, 0);
      send_byte(8'h42, dn);
      stop_c();
      cyc(4);
      chk(rx_cnt - base_rx == 1, "R2 partial byte discarded", rx_cnt - base_rx, 1);
      chk(rx_last == 8'h42, "R2 byte after repeated START", rx_last, 8'h42);

      // R3: STOP mid-byte, then clocking without START is ignored
      base_rx = rx_cnt;
      start_c();
      send_byte({OWN, 1'b0}, an);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      stop_c();
      chk(sda_oe == 1'b0, "R3 SDA released at STOP", sda_oe, 0);
      scl_c = 1'b0;
      cyc(H);
      send_byte({OWN, 1'b0}, an);
      chk(an == 1'b1, "R3 no ack without START", an, 1);
      send_byte(8'h99, dn);
      stop_c();
      cyc(4);
      chk(rx_cnt == base_rx, "R3 no strobe while idle", rx_cnt - base_rx, 0);

      summary();
      $finish;
   end
endmodule